// File: doc/BRIEF.md
# Color Pattern Buffer Lookup

This block holds an 8x8 color fill pattern inside a fixed window of a shared lookup buffer and returns the pattern pixel for a screen position. Software loads the window through a register pair. One port sets a DWORD index. The other port stores a DWORD at that index, and the index then steps forward by one, so a whole pattern can be streamed in after a single index write.

At draw time the requester presents the low coordinate bits x and y, the depth the pattern was stored in, and the depth the raster pipeline expects. One clock later the block returns the matching pixel, converted to the raster depth, together with a strobe and an error flag for an illegal depth. The block also keeps track of which window DWORDs have been loaded since the buffer was last taken over for non-pattern use. From that record it reports whether a complete pattern for the selected depth is present.

Top module: `cpat_lut`

## Requirements
- R1: A pulse on `idx_wr_i` loads `idx_i` into the index. A pulse on `data_wr_i` stores `data_i` at the index, and the index then increments by one, wrapping from 1FFh to 0. When both pulses arrive in the same cycle, the index write wins and the data is dropped.
- R2: Only data writes whose index lies in 100h..13Fh change the pattern window. Writes to any other index leave every pattern pixel unchanged.
- R3: Pixel (x, y) has number n = y*8+x and a byte offset o = n*B, where B is 1, 2 or 4 bytes per pixel. It is read from window DWORD 100h + o/4, and its lowest byte sits in lane o mod 4. Lane 0 is bits 7:0 (little-endian). An 8-bpp pattern therefore spans 100h..10Fh, a 16-bpp pattern spans 100h..11Fh and a 32-bpp pattern spans 100h..13Fh.
- R4: The depth codes on `pat_bpp_i` and `ras_bpp_i` are 0 = 4 bpp, 1 = 8 bpp, 2 = 16 bpp and 3 = 32 bpp. `rsp_valid_o` is high exactly in the cycle after a cycle with `req_i` high, and `pix_o` and `err_o` are valid in that cycle.
- R5: When either depth code is 0 in a request, the response has `err_o` = 1 and `pix_o` = 0. Otherwise `err_o` = 0.
- R6: The pixel formats are RGB 3:3:2 in bits 7:0, RGB 5:6:5 in bits 15:0, and RGB 8:8:8 in bits 23:0. Unused high bits of `pix_o` are 0, so bits 31:24 of a 32-bpp result are always 0. When the two depths differ, each channel is converted separately. A channel that widens keeps its bits at the top and fills zeros below them. A channel that narrows keeps its top bits.
- R7: `pat_valid_o` is 1 when every window DWORD the selected `pat_bpp_i` needs (16, 32 or 64 from 100h) has been written since the last clear. It is 0 for depth code 0.
- R8: A pulse on `nonpat_use_i` forgets all loaded DWORDs, so `pat_valid_o` is 0 in the next cycle. This holds even when a window write arrives in the same cycle.
- R9: After reset, `pat_valid_o` and `rsp_valid_o` are 0 and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_wr_i | input | 1 | Index register write strobe |
| idx_i | input | IDX_W (9) | New index value |
| data_wr_i | input | 1 | Data register write strobe |
| data_i | input | 32 | DWORD to store |
| nonpat_use_i | input | 1 | Buffer taken for non-pattern use; pattern is lost |
| req_i | input | 1 | Lookup request |
| x_i | input | XY_W (3) | Low bits of pixel x |
| y_i | input | XY_W (3) | Low bits of pixel y |
| pat_bpp_i | input | 2 | Stored pattern depth code |
| ras_bpp_i | input | 2 | Raster output depth code |
| rsp_valid_o | output | 1 | Lookup result strobe |
| err_o | output | 1 | Illegal depth in the request |
| pix_o | output | 32 | Pattern pixel in raster format |
| pat_valid_o | output | 1 | Full pattern present for pat_bpp_i |

## Verification
The bench builds the block with the default parameters: an 8x8 pattern, a 9-bit index and the window based at 100h. With these values the index wrap from 1FFh to 0, the window edges at 0FFh/100h and 13Fh/140h, and all three window sizes can be reached in a few hundred cycles. The bench keeps its own model of the window, so it can check every depth pair, including both directions of channel conversion, against pixels taken from the first, middle and last DWORDs of each window.

// File: rtl/cpat_pkg.sv
package cpat_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    BPP4  = 2'd0,
    BPP8  = 2'd1,
    BPP16 = 2'd2,
    BPP32 = 2'd3
  } bpp_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // MSB-aligned expansion to 8 bits per channel
  function automatic rgb_t px_unpack(logic [WORD_W-1:0] raw, bpp_e bpp);
    rgb_t c;
    c = '0;
    unique case (bpp)
      BPP8: begin
        c.r = {raw[7:5], 5'b0};
        c.g = {raw[4:2], 5'b0};
        c.b = {raw[1:0], 6'b0};
      end
      BPP16: begin
        c.r = {raw[15:11], 3'b0};
        c.g = {raw[10:5], 2'b0};
        c.b = {raw[4:0], 3'b0};
      end
      BPP32: c = raw[23:0];
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] px_pack(rgb_t c, bpp_e bpp);
    logic [WORD_W-1:0] p;
    unique case (bpp)
      BPP8:    p = {24'b0, c.r[7:5], c.g[7:5], c.b[7:6]};
      BPP16:   p = {16'b0, c.r[7:3], c.g[7:2], c.b[7:3]};
      BPP32:   p = {8'b0, c};
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/cpat_loader.sv
module cpat_loader #(
  parameter int IDX_W     = 9,
  parameter int BASE      = 256,
  parameter int WIN_WORDS = 64,
  localparam int WIN_AW   = $clog2(WIN_WORDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       idx_wr_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic                       data_wr_i,
  input  logic                       clr_i,
  output logic                       wr_en_o,
  output logic [WIN_AW-1:0]          wr_addr_o,
  output logic [WIN_WORDS-1:0]       mask_o,
  output logic [IDX_W-1:0]           idx_o
);
  localparam logic [IDX_W-1:0] BASE_L = IDX_W'(BASE);
  localparam logic [IDX_W-1:0] SIZE_L = IDX_W'(WIN_WORDS);

  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     rel;
  logic                 in_win;
  logic [WIN_WORDS-1:0] mask_q;

  assign rel       = idx_q - BASE_L;
  assign in_win    = (idx_q >= BASE_L) && (rel < SIZE_L);
  assign wr_en_o   = data_wr_i && !idx_wr_i && in_win;
  assign wr_addr_o = rel[WIN_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (idx_wr_i)  idx_q <= idx_i;
    else if (data_wr_i) idx_q <= idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (clr_i)   mask_q <= '0;
    else if (wr_en_o) mask_q[wr_addr_o] <= 1'b1;
  end

  assign mask_o = mask_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/cpat_store.sv
module cpat_store #(
  parameter int WIN_WORDS = 64,
  parameter int WORD_W    = 32,
  localparam int WIN_AW   = $clog2(WIN_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIN_AW-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [WIN_AW-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem [WIN_WORDS];
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/cpat_fmt.sv
module cpat_fmt
  import cpat_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        lane_i,
  input  logic [1:0]        pat_bpp_i,
  input  logic [1:0]        ras_bpp_i,
  input  logic              err_i,
  output logic [WORD_W-1:0] pix_o
);
  logic [WORD_W-1:0] shifted;
  rgb_t              c;

  always_comb begin
    shifted = word_i >> {lane_i, 3'b000};
    c       = px_unpack(shifted, bpp_e'(pat_bpp_i));
    pix_o   = err_i ? '0 : px_pack(c, bpp_e'(ras_bpp_i));
  end
endmodule

// File: rtl/cpat_lut.sv
module cpat_lut
  import cpat_pkg::*;
#(
  parameter int IDX_W    = 9,
  parameter int BASE     = 256,
  parameter int PAT_DIM  = 8,
  localparam int XY_W    = $clog2(PAT_DIM),
  localparam int PIX_N   = PAT_DIM * PAT_DIM,
  localparam int PIX_AW  = $clog2(PIX_N),
  localparam int WIN_WORDS = PIX_N,
  localparam int WIN_AW  = PIX_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              data_wr_i,
  input  logic [31:0]       data_i,
  input  logic              nonpat_use_i,
  input  logic              req_i,
  input  logic [XY_W-1:0]   x_i,
  input  logic [XY_W-1:0]   y_i,
  input  logic [1:0]        pat_bpp_i,
  input  logic [1:0]        ras_bpp_i,
  output logic              rsp_valid_o,
  output logic              err_o,
  output logic [31:0]       pix_o,
  output logic              pat_valid_o
);
  logic                 wr_en;
  logic [WIN_AW-1:0]    wr_addr;
  logic [WIN_WORDS-1:0] mask;
  logic [IDX_W-1:0]     idx_q;

  cpat_loader #(.IDX_W(IDX_W), .BASE(BASE), .WIN_WORDS(WIN_WORDS)) u_loader (
    .clk_i, .rst_ni, .idx_wr_i, .idx_i, .data_wr_i,
    .clr_i(nonpat_use_i), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .mask_o(mask), .idx_o(idx_q)
  );

  // Pixel addressing: byte offset = n * bytes_per_pixel
  logic [PIX_AW-1:0]   pix_n;
  logic [PIX_AW+1:0]   off;
  logic                bad_req;
  logic [WIN_AW-1:0]   rd_addr;

  always_comb begin
    pix_n = {y_i, x_i};
    unique case (bpp_e'(pat_bpp_i))
      BPP16:   off = {1'b0, pix_n, 1'b0};
      BPP32:   off = {pix_n, 2'b00};
      default: off = {2'b00, pix_n};
    endcase
    rd_addr = off[PIX_AW+1:2];
    bad_req = (pat_bpp_i == BPP4) || (ras_bpp_i == BPP4);
  end

  logic [31:0] word;

  cpat_store #(.WIN_WORDS(WIN_WORDS), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(data_i),
    .rd_en_i(req_i), .rd_addr_i(rd_addr), .rd_data_o(word)
  );

  logic       rsp_q, err_q;
  logic [1:0] lane_q, pbpp_q, rbpp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q  <= 1'b0;
      err_q  <= 1'b0;
      lane_q <= '0;
      pbpp_q <= '0;
      rbpp_q <= '0;
    end else begin
      rsp_q <= req_i;
      if (req_i) begin
        err_q  <= bad_req;
        lane_q <= off[1:0];
        pbpp_q <= pat_bpp_i;
        rbpp_q <= ras_bpp_i;
      end
    end
  end

  cpat_fmt u_fmt (
    .word_i(word), .lane_i(lane_q), .pat_bpp_i(pbpp_q), .ras_bpp_i(rbpp_q),
    .err_i(err_q), .pix_o(pix_o)
  );

  assign rsp_valid_o = rsp_q;
  assign err_o       = rsp_q && err_q;

  // Words a complete pattern needs at the selected depth
  logic [WIN_WORDS-1:0] need;
  int unsigned          need_cnt;

  always_comb begin
    unique case (bpp_e'(pat_bpp_i))
      BPP8:    need_cnt = WIN_WORDS / 4;
      BPP16:   need_cnt = WIN_WORDS / 2;
      BPP32:   need_cnt = WIN_WORDS;
      default: need_cnt = 0;
    endcase
    for (int i = 0; i < WIN_WORDS; i++) need[i] = (i < need_cnt);
  end

  assign pat_valid_o = (pat_bpp_i != BPP4) && ((mask & need) == need);
endmodule

// File: rtl/cpat_lut_chk.sv
module cpat_lut_chk #(
  parameter int IDX_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idx_wr_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             data_wr_i,
  input logic             nonpat_use_i,
  input logic             req_i,
  input logic [1:0]       pat_bpp_i,
  input logic [1:0]       ras_bpp_i,
  input logic             rsp_valid_o,
  input logic             err_o,
  input logic [31:0]      pix_o,
  input logic             pat_valid_o,
  input logic [IDX_W-1:0] idx_q
);
  assert_idx_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> idx_q == $past(idx_i));

  assert_idx_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !idx_wr_i) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

  assert_rsp_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  assert_rsp_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  assert_err_on_4bpp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (pat_bpp_i == 2'd0 || ras_bpp_i == 2'd0)) |=> err_o);

  assert_err_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && err_o) |-> pix_o == 32'd0);

  assert_top_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !err_o) |-> pix_o[31:24] == 8'd0);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonpat_use_i |=> !pat_valid_o);
endmodule

bind cpat_lut cpat_lut_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .idx_wr_i, .idx_i, .data_wr_i, .nonpat_use_i, .req_i,
  .pat_bpp_i, .ras_bpp_i, .rsp_valid_o, .err_o, .pix_o, .pat_valid_o,
  .idx_q(idx_q)
);

// File: tb/tb_cpat_lut.sv
`timescale 1ns/1ps
module tb_cpat_lut;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        idx_wr = 0, data_wr = 0, nonpat = 0, req = 0;
  logic [8:0]  idx = '0;
  logic [31:0] data = '0;
  logic [2:0]  x = '0, y = '0;
  logic [1:0]  pb = 2'd1, rb = 2'd1;
  logic        rsp_valid, err, pat_valid;
  logic [31:0] pix;

  int checks = 0, fails = 0, bidx = 0;
  bit done = 0;
  logic [31:0] model [64];

  always #2.5 clk = ~clk;

  cpat_lut dut (
    .clk_i(clk), .rst_ni(rst_n), .idx_wr_i(idx_wr), .idx_i(idx),
    .data_wr_i(data_wr), .data_i(data), .nonpat_use_i(nonpat), .req_i(req),
    .x_i(x), .y_i(y), .pat_bpp_i(pb), .ras_bpp_i(rb),
    .rsp_valid_o(rsp_valid), .err_o(err), .pix_o(pix), .pat_valid_o(pat_valid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(int k, int seed);
    return 32'(k * 32'h0103_0507) ^ 32'(seed * 32'h9E37_79B9);
  endfunction

  // Channel widths: [0]=r [1]=g [2]=b
  function automatic int chw(int bpp, int ch);
    case (bpp)
      1: return (ch == 2) ? 2 : 3;
      2: return (ch == 1) ? 6 : 5;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] expect_pix(int xx, int yy, int p, int r);
    int n, bpp_b, o;
    logic [31:0] raw, res;
    int pos_s, pos_d;
    if (p == 0 || r == 0) return 32'd0;
    n = yy * 8 + xx;
    bpp_b = (p == 1) ? 1 : (p == 2) ? 2 : 4;
    o = n * bpp_b;
    raw = model[o / 4] >> (8 * (o % 4));
    res = '0;
    pos_s = 0; pos_d = 0;
    for (int ch = 2; ch >= 0; ch--) begin
      int ws = chw(p, ch), wd = chw(r, ch);
      logic [7:0] v8;
      v8 = 8'((raw >> pos_s) & ((32'd1 << ws) - 1)) << (8 - ws);
      res |= 32'(v8 >> (8 - wd)) << pos_d;
      pos_s += ws; pos_d += wd;
    end
    return res;
  endfunction

  task automatic set_idx(int v);
    @(negedge clk); idx_wr = 1; idx = 9'(v);
    @(negedge clk); idx_wr = 0;
    bidx = v;
  endtask

  task automatic put(logic [31:0] d);
    @(negedge clk); data_wr = 1; data = d;
    @(negedge clk); data_wr = 0;
    if (bidx >= 256 && bidx < 320) model[bidx - 256] = d;
    bidx = (bidx + 1) % 512;
  endtask

  task automatic load(int n, int seed);
    set_idx(256);
    for (int k = 0; k < n; k++) put(gen(k, seed));
  endtask

  task automatic look(int xx, int yy, int p, int r, string tag);
    @(negedge clk); req = 1; x = 3'(xx); y = 3'(yy); pb = 2'(p); rb = 2'(r);
    @(negedge clk); req = 0;
    check({tag, " strobe R4"}, 32'(rsp_valid), 32'd1);
    check({tag, " pix R3"}, pix, expect_pix(xx, yy, p, r));
    check({tag, " err R5"}, 32'(err), (p == 0 || r == 0) ? 32'd1 : 32'd0);
  endtask

  task automatic pat_valid_is(int p, logic exp, string tag);
    @(negedge clk); pb = 2'(p);
    #1 check(tag, 32'(pat_valid), 32'(exp));
  endtask

  task automatic t_reset;
    check("reset pat_valid R9", 32'(pat_valid), 32'd0);
    check("reset rsp_valid R9", 32'(rsp_valid), 32'd0);
    // index resets to 0: first data write is outside the window
    put(32'hDEAD_BEEF);
    pat_valid_is(1, 1'b0, "reset index R9");
  endtask

  task automatic t_load_valid;
    load(16, 1);
    pat_valid_is(1, 1'b1, "8bpp window loaded R7");
    pat_valid_is(2, 1'b0, "16bpp window partial R7");
    pat_valid_is(0, 1'b0, "4bpp never valid R7");
    for (int k = 16; k < 64; k++) put(gen(k, 1));
    pat_valid_is(2, 1'b1, "16bpp window loaded R7");
    pat_valid_is(3, 1'b1, "32bpp window loaded R7");
  endtask

  task automatic t_same_depth;
    look(0, 0, 1, 1, "8bpp(0,0)");
    look(5, 3, 1, 1, "8bpp(5,3)");
    look(7, 7, 1, 1, "8bpp(7,7)");
    look(1, 0, 2, 2, "16bpp(1,0)");
    look(6, 4, 2, 2, "16bpp(6,4)");
    look(7, 7, 2, 2, "16bpp(7,7)");
    look(0, 0, 3, 3, "32bpp(0,0) R6");
    look(3, 5, 3, 3, "32bpp(3,5) R6");
    look(7, 7, 3, 3, "32bpp(7,7) R6");
    @(negedge clk);
    check("strobe drops R4", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_convert;
    look(2, 1, 3, 1, "32to8 R6");
    look(4, 6, 3, 2, "32to16 R6");
    look(1, 2, 1, 3, "8to32 R6");
    look(7, 0, 1, 2, "8to16 R6");
    look(3, 3, 2, 1, "16to8 R6");
    look(5, 7, 2, 3, "16to32 R6");
  endtask

  task automatic t_illegal;
    look(2, 2, 0, 3, "pat4bpp R5");
    look(2, 2, 3, 0, "ras4bpp R5");
    look(6, 1, 0, 0, "both4bpp R5");
  endtask

  task automatic t_index;
    // simultaneous index + data write: data dropped
    @(negedge clk); idx_wr = 1; idx = 9'h100; data_wr = 1; data = 32'h1111_2222;
    @(negedge clk); idx_wr = 0; data_wr = 0; bidx = 256;
    put(32'h00AB_CDEF);
    look(0, 0, 3, 3, "idx priority R1");
    set_idx(9'h0FF);
    put(32'h0011_2233);
    put(32'h0044_5566);
    look(0, 0, 3, 3, "idx increment R1");
    set_idx(9'h1FF);
    put(32'h0077_8899);
    put(32'h00AA_BBCC);
    put(32'h00DD_EEFF);
    look(0, 0, 3, 3, "idx wrap R1");
    look(1, 0, 3, 3, "idx wrap next R1");
  endtask

  task automatic t_window;
    set_idx(9'h13F);
    put(32'h0012_3456);
    put(32'h00FE_DCBA);
    look(7, 7, 3, 3, "last window word R2");
    look(6, 7, 3, 3, "neighbour word R2");
  endtask

  task automatic t_clear;
    load(64, 2);
    @(negedge clk); nonpat = 1;
    @(negedge clk); nonpat = 0;
    pat_valid_is(1, 1'b0, "clear 8bpp R8");
    pat_valid_is(3, 1'b0, "clear 32bpp R8");
    set_idx(256);
    for (int k = 0; k < 15; k++) put(gen(k, 3));
    @(negedge clk); data_wr = 1; data = gen(15, 3); nonpat = 1;
    @(negedge clk); data_wr = 0; nonpat = 0; model[15] = gen(15, 3); bidx = 272;
    pat_valid_is(1, 1'b0, "clear beats write R8");
    load(16, 4);
    pat_valid_is(1, 1'b1, "reload 8bpp R7");
    pat_valid_is(2, 1'b0, "reload partial 16bpp R7");
    look(7, 3, 1, 1, "reloaded pixel R3");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1 t_reset_pre();
    rst_n = 1'b1;
    t_reset();
    t_load_valid();
    t_same_depth();
    t_convert();
    t_illegal();
    t_index();
    t_window();
    t_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic t_reset_pre;
    check("in reset rsp_valid R9", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R4 act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule